// File: doc/BRIEF.md
# Nybble-Serial 16-Bit Register Datapath

This block performs 16-bit register-to-register arithmetic and logic using a 4-bit ALU. It handles one nybble per clock, so a full-width operation takes four clocks. The four 16-bit registers live in a 16-entry by 4-bit register RAM. The register select forms the upper RAM address bits, and a 2-bit nybble counter forms the lower bits. The counter steps from the least significant nybble to the most significant one. A flip-flop saves the carry out of each nybble and feeds it into the next one. The carry out of the top nybble is kept as a flag.

Each result nybble is written back to the destination register. In the same cycle it is shifted into a flip-flop address register. When the operation ends, that register presents the whole 16-bit result to memory. Register 0 always reads as zero.

A surrounding controller supplies the following with a one-cycle start pulse:
- the operation code,
- the destination register and the two source registers,
- the operand-B source (register or a 16-bit immediate),
- a carry-in for the lowest nybble.

Adding register 0 with a carry-in of 1 is how the controller increments a program counter held in a register. A new start is accepted in the final cycle of the previous operation, so operations can run back to back with no gap.

Top module: `nyb_dp`

## Requirements
- R1: After reset, busy, done and carry_flag are 0 and addr_out is 0x0000.
- R2: An accepted start makes busy high for exactly four clocks. done is high only in the fourth of those clocks, the one in which the most significant nybble is written back.
- R3: Nybbles are processed least significant first, and each result nybble enters the address register at its top end. One cycle before the last nybble is written, addr_out[15:4] therefore holds result bits 11:0. After done, addr_out holds the full 16-bit result.
- R4: Op code 2'b00 (ADD) computes A + B + carry_in. The carry is chained between nybbles, and carry_flag takes the carry out of bit 15.
- R5: Op code 2'b01 (SUB) computes A + ~B + 1, and the carry_in input is ignored. carry_flag is 1 when no borrow occurs (A >= B) and 0 otherwise.
- R6: Op code 2'b10 (AND) and op code 2'b11 (XOR) compute the bitwise result and clear carry_flag.
- R7: Register 0 reads as zero on both operand ports. An operation whose destination is register 0 leaves register 0 unchanged, although its result still reaches addr_out.
- R8: When use_imm is 1, operand B is taken from imm_val, captured at start, instead of the B register.
- R9: A start pulse during any cycle of an operation other than its done cycle is ignored. It has no effect on timing, result or registers.
- R10: A start pulse in the done cycle is accepted. The new operation begins on the next clock and reads the register contents just completed.
- R11: Adding register 0 with carry_in 1 increments a register. The carry ripples through every nybble: 0x0FFF becomes 0x1000 with flag 0, and 0xFFFF becomes 0x0000 with flag 1.
- R12: While idle, addr_out and carry_flag hold their values whatever the operand inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin an operation |
| op | input | 2 | 00 ADD, 01 SUB, 10 AND, 11 XOR |
| dst_sel | input | 2 | Destination register |
| a_sel | input | 2 | Operand A register |
| b_sel | input | 2 | Operand B register |
| use_imm | input | 1 | Take operand B from imm_val |
| imm_val | input | 16 | Immediate operand, captured at start |
| carry_in | input | 1 | Carry into the lowest nybble for ADD |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Final nybble being written this cycle |
| carry_flag | output | 1 | Carry out of the last completed operation |
| addr_out | output | 16 | Address register assembled from result nybbles |

## Verification
The completion of one operation and the acceptance of the next can fall in the same cycle. In that cycle the top nybble of the destination is written while the sequencer reloads for the following operation. The bench provokes this by pulsing start exactly when done is high, with the second operation reading the register the first one writes. It judges the result by comparing the second result against a model that applies the first result before computing the second. A start placed in an earlier cycle of an operation is also driven, and the bench confirms it leaves the timing, the result and the other registers untouched.

// File: rtl/nyb_dp_pkg.sv
package nyb_dp_pkg;
   typedef enum logic [1:0] {
      OP_ADD = 2'b00,
      OP_SUB = 2'b01,
      OP_AND = 2'b10,
      OP_XOR = 2'b11
   } alu_op_e;
endpackage

// File: rtl/nyb_regram.sv
module nyb_regram #(
   parameter int NYB_W    = 4,
   parameter int NUM_NYB  = 4,
   parameter int NUM_REGS = 4
) (
   input  logic                        clk,
   input  logic                        we,
   input  logic [$clog2(NUM_REGS)-1:0] wr_reg,
   input  logic [$clog2(NUM_NYB)-1:0]  nyb_idx,
   input  logic [NYB_W-1:0]            wr_data,
   input  logic [$clog2(NUM_REGS)-1:0] rd_a_reg,
   input  logic [$clog2(NUM_REGS)-1:0] rd_b_reg,
   output logic [NYB_W-1:0]            rd_a,
   output logic [NYB_W-1:0]            rd_b
);
   localparam int SEL_W = $clog2(NUM_REGS);
   localparam int CNT_W = $clog2(NUM_NYB);
   localparam int DEPTH = NUM_REGS * NUM_NYB;

   logic [NYB_W-1:0] mem [DEPTH];

   // register 0 is never stored: writes to it are dropped, reads return zero
   always_ff @(posedge clk) begin
      if (we && (wr_reg != '0))
         mem[{wr_reg, nyb_idx}] <= wr_data;
   end

   assign rd_a = (rd_a_reg == '0) ? '0 : mem[{rd_a_reg, nyb_idx}];
   assign rd_b = (rd_b_reg == '0) ? '0 : mem[{rd_b_reg, nyb_idx}];

   if (SEL_W + CNT_W != $clog2(DEPTH)) begin : g_bad_depth
      $error("nyb_regram: depth is not a power of two");
   end
endmodule

// File: rtl/nyb_alu.sv
module nyb_alu
   import nyb_dp_pkg::*;
#(
   parameter int NYB_W = 4
) (
   input  alu_op_e          op,
   input  logic [NYB_W-1:0] a,
   input  logic [NYB_W-1:0] b,
   input  logic             cin,
   output logic [NYB_W-1:0] res,
   output logic             cout
);
   logic [NYB_W:0] sum;
   logic [NYB_W-1:0] b_eff;

   always_comb begin
      b_eff = (op == OP_SUB) ? ~b : b;
      sum   = {1'b0, a} + {1'b0, b_eff} + {{NYB_W{1'b0}}, cin};
      case (op)
         OP_ADD, OP_SUB: begin res = sum[NYB_W-1:0]; cout = sum[NYB_W]; end
         OP_AND:         begin res = a & b;          cout = 1'b0;       end
         default:        begin res = a ^ b;          cout = 1'b0;       end
      endcase
   end
endmodule

// File: rtl/nyb_seq.sv
module nyb_seq #(
   parameter int NUM_NYB = 4
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       start,
   output logic                       accept,
   output logic                       busy,
   output logic                       first,
   output logic                       last,
   output logic [$clog2(NUM_NYB)-1:0] cnt
);
   localparam int CNT_W = $clog2(NUM_NYB);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(NUM_NYB - 1);

   assign first  = busy && (cnt == '0);
   assign last   = busy && (cnt == CNT_LAST);
   assign accept = start && (!busy || last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         cnt  <= '0;
      end else if (accept) begin
         busy <= 1'b1;
         cnt  <= '0;
      end else if (last) begin
         busy <= 1'b0;
         cnt  <= '0;
      end else if (busy) begin
         cnt  <= cnt + 1'b1;
      end
   end

   AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy) && !$past(last)) |-> (cnt == CNT_W'($past(cnt) + 1'b1))); // R2
   AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(busy) && !$past(last) && $past(start)) |-> (cnt != '0)); // R9
endmodule

// File: rtl/nyb_dp.sv
module nyb_dp
   import nyb_dp_pkg::*;
#(
   parameter int NYB_W    = 4,
   parameter int NUM_NYB  = 4,
   parameter int NUM_REGS = 4
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          start,
   input  logic [1:0]                    op,
   input  logic [$clog2(NUM_REGS)-1:0]   dst_sel,
   input  logic [$clog2(NUM_REGS)-1:0]   a_sel,
   input  logic [$clog2(NUM_REGS)-1:0]   b_sel,
   input  logic                          use_imm,
   input  logic [NYB_W*NUM_NYB-1:0]      imm_val,
   input  logic                          carry_in,
   output logic                          busy,
   output logic                          done,
   output logic                          carry_flag,
   output logic [NYB_W*NUM_NYB-1:0]      addr_out
);
   localparam int WORD_W = NYB_W * NUM_NYB;
   localparam int SEL_W  = $clog2(NUM_REGS);
   localparam int CNT_W  = $clog2(NUM_NYB);

   if (NYB_W < 1 || NUM_NYB < 2 || NUM_REGS < 2) begin : g_bad_params
      $error("nyb_dp: NYB_W must be >= 1, NUM_NYB and NUM_REGS >= 2");
   end

   logic             accept, first, last;
   logic [CNT_W-1:0] cnt;

   alu_op_e          op_q;
   logic [SEL_W-1:0] dst_q, a_q, b_q;
   logic             imm_q, cin_q;
   logic [WORD_W-1:0] imm_sh;
   logic             carry_q, flag_q;

   logic [NYB_W-1:0] rd_a, rd_b, b_nyb, res;
   logic             cin_eff, cout;

   nyb_seq #(.NUM_NYB(NUM_NYB)) u_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .accept(accept),
      .busy(busy), .first(first), .last(last), .cnt(cnt)
   );

   // operation fields are captured once, the sources may change afterwards
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op_q  <= OP_ADD;
         dst_q <= '0;
         a_q   <= '0;
         b_q   <= '0;
         imm_q <= 1'b0;
         cin_q <= 1'b0;
      end else if (accept) begin
         op_q  <= alu_op_e'(op);
         dst_q <= dst_sel;
         a_q   <= a_sel;
         b_q   <= b_sel;
         imm_q <= use_imm;
         cin_q <= carry_in;
      end
   end

   // immediate is consumed low nybble first by shifting it right
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      imm_sh <= '0;
      else if (accept) imm_sh <= imm_val;
      else if (busy)   imm_sh <= imm_sh >> NYB_W;
   end

   nyb_regram #(.NYB_W(NYB_W), .NUM_NYB(NUM_NYB), .NUM_REGS(NUM_REGS)) u_ram (
      .clk(clk), .we(busy), .wr_reg(dst_q), .nyb_idx(cnt), .wr_data(res),
      .rd_a_reg(a_q), .rd_b_reg(b_q), .rd_a(rd_a), .rd_b(rd_b)
   );

   assign b_nyb   = imm_q ? imm_sh[NYB_W-1:0] : rd_b;
   assign cin_eff = first ? ((op_q == OP_SUB) ? 1'b1 : cin_q) : carry_q;

   nyb_alu #(.NYB_W(NYB_W)) u_alu (
      .op(op_q), .a(rd_a), .b(b_nyb), .cin(cin_eff), .res(res), .cout(cout)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         carry_q <= 1'b0;
         flag_q  <= 1'b0;
      end else if (busy) begin
         carry_q <= cout;
         if (last) flag_q <= cout;
      end
   end

   // address register: a chain of nybble slots, result enters at the top
   logic [NYB_W-1:0] addr_nyb [NUM_NYB];
   for (genvar i = 0; i < NUM_NYB; i++) begin : g_addr
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)    addr_nyb[i] <= '0;
         else if (busy) begin
            if (i == NUM_NYB - 1) addr_nyb[i] <= res;
            else                  addr_nyb[i] <= addr_nyb[(i + 1) % NUM_NYB];
         end
      end
      assign addr_out[i*NYB_W +: NYB_W] = addr_nyb[i];
   end

   assign done       = last;
   assign carry_flag = flag_q;

   AST_R0_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && a_q == '0) |-> (rd_a == '0)); // R7
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !$past(busy)) |-> ($stable(addr_out) && $stable(carry_flag))); // R12
   AST_LOGIC_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(done) && ($past(op_q) == OP_AND || $past(op_q) == OP_XOR)) |-> !carry_flag); // R6
   AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(done) && !$past(start)) |-> !busy); // R2
endmodule

// File: tb/nyb_dp_bench.sv
module nyb_dp_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [1:0]  op = 2'b00;
   logic [1:0]  dst_sel = '0, a_sel = '0, b_sel = '0;
   logic        use_imm = 1'b0;
   logic [15:0] imm_val = '0;
   logic        carry_in = 1'b0;
   logic        busy, done, carry_flag;
   logic [15:0] addr_out;

   int n_chk = 0;
   int n_fail = 0;
   logic [15:0] model [4];
   logic [15:0] exp_res;
   logic        exp_c;

   always #4 clk = ~clk;

   nyb_dp u_nyb_dp (
      .clk(clk), .rst_n(rst_n), .start(start), .op(op), .dst_sel(dst_sel),
      .a_sel(a_sel), .b_sel(b_sel), .use_imm(use_imm), .imm_val(imm_val),
      .carry_in(carry_in), .busy(busy), .done(done), .carry_flag(carry_flag),
      .addr_out(addr_out)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // independent 16-bit model, applied in program order
   task automatic calc(input logic [1:0] o, input logic [1:0] d, input logic [1:0] a,
                       input logic [1:0] b, input logic ui, input logic [15:0] im,
                       input logic ci);
      logic [15:0] av, bv;
      logic [16:0] s;
      av = (a == 0) ? 16'h0 : model[a];
      bv = ui ? im : ((b == 0) ? 16'h0 : model[b]);
      case (o)
         2'b00:   s = {1'b0, av} + {1'b0, bv} + {16'h0, ci};
         2'b01:   s = {1'b0, av} + {1'b0, ~bv} + 17'h1;
         2'b10:   s = {1'b0, av & bv};
         default: s = {1'b0, av ^ bv};
      endcase
      exp_res = s[15:0];
      exp_c   = s[16];
      if (d != 0) model[d] = s[15:0];
   endtask

   task automatic drive(input logic [1:0] o, input logic [1:0] d, input logic [1:0] a,
                        input logic [1:0] b, input logic ui, input logic [15:0] im,
                        input logic ci);
      op = o; dst_sel = d; a_sel = a; b_sel = b; use_imm = ui; imm_val = im;
      carry_in = ci; start = 1'b1;
   endtask

   task automatic run_op(input string tag, input logic [1:0] o, input logic [1:0] d,
                         input logic [1:0] a, input logic [1:0] b, input logic ui,
                         input logic [15:0] im, input logic ci);
      calc(o, d, a, b, ui, im, ci);
      drive(o, d, a, b, ui, im, ci);
      @(negedge clk); start = 1'b0;
      check({tag, " R2 busy"}, busy, 1);
      @(negedge clk); @(negedge clk);
      check({tag, " R2 no early done"}, done, 0);
      @(negedge clk);
      check({tag, " R2 done"}, done, 1);
      check({tag, " R3 partial addr"}, addr_out[15:4], exp_res[11:0]);
      @(negedge clk);
      check({tag, " R2 idle"}, busy, 0);
      check({tag, " result"}, addr_out, exp_res);
      check({tag, " flag"}, carry_flag, exp_c);
   endtask

   task automatic load(input logic [1:0] d, input logic [15:0] v);
      run_op("R8 load", 2'b00, d, 2'd0, 2'd0, 1'b1, v, 1'b0);
   endtask

   task automatic t_reset;
      check("R1 busy", busy, 0);
      check("R1 done", done, 0);
      check("R1 flag", carry_flag, 0);
      check("R1 addr", addr_out, 0);
   endtask

   task automatic t_add;
      load(2'd1, 16'h1234);
      load(2'd2, 16'h0FCD);
      run_op("R4 add", 2'b00, 2'd3, 2'd1, 2'd2, 1'b0, 16'h0, 1'b0);
      run_op("R4 add cin", 2'b00, 2'd3, 2'd1, 2'd2, 1'b0, 16'h0, 1'b1);
      load(2'd2, 16'hFFFF);
      run_op("R4 add overflow", 2'b00, 2'd3, 2'd1, 2'd2, 1'b0, 16'h0, 1'b0);
   endtask

   task automatic t_sub;
      load(2'd1, 16'h1000);
      load(2'd2, 16'h0001);
      run_op("R5 sub no borrow", 2'b01, 2'd3, 2'd1, 2'd2, 1'b0, 16'h0, 1'b0);
      run_op("R5 sub borrow", 2'b01, 2'd3, 2'd2, 2'd1, 1'b0, 16'h0, 1'b1);
      run_op("R5 sub equal", 2'b01, 2'd3, 2'd1, 2'd1, 1'b0, 16'h0, 1'b0);
   endtask

   task automatic t_logic;
      load(2'd1, 16'hF0A5);
      run_op("R6 and", 2'b10, 2'd2, 2'd1, 2'd0, 1'b1, 16'h3C3C, 1'b1);
      run_op("R6 xor", 2'b11, 2'd3, 2'd1, 2'd2, 1'b0, 16'h0, 1'b1);
   endtask

   task automatic t_zero;
      load(2'd1, 16'hBEEF);
      run_op("R7 write r0", 2'b00, 2'd0, 2'd1, 2'd0, 1'b0, 16'h0, 1'b0);
      run_op("R7 read r0", 2'b00, 2'd2, 2'd0, 2'd0, 1'b0, 16'h0, 1'b0);
      run_op("R8 imm plus r0", 2'b11, 2'd2, 2'd0, 2'd1, 1'b1, 16'h5A5A, 1'b0);
   endtask

   task automatic t_inc;
      load(2'd1, 16'h0FFF);
      run_op("R11 inc ripple", 2'b00, 2'd1, 2'd1, 2'd0, 1'b0, 16'h0, 1'b1);
      load(2'd1, 16'hFFFF);
      run_op("R11 inc wrap", 2'b00, 2'd1, 2'd1, 2'd0, 1'b0, 16'h0, 1'b1);
   endtask

   task automatic t_ignore;
      logic [15:0] e1;
      logic        c1;
      load(2'd1, 16'h0102);
      load(2'd2, 16'h7777);
      calc(2'b00, 2'd3, 2'd1, 2'd1, 1'b0, 16'h0, 1'b0);
      e1 = exp_res; c1 = exp_c;
      drive(2'b00, 2'd3, 2'd1, 2'd1, 1'b0, 16'h0, 1'b0);
      @(negedge clk); start = 1'b0;
      @(negedge clk);
      drive(2'b11, 2'd2, 2'd1, 2'd1, 1'b0, 16'h0, 1'b0); // would clear r2
      @(negedge clk); start = 1'b0;
      @(negedge clk);
      check("R9 done on time", done, 1);
      @(negedge clk);
      check("R9 no restart", busy, 0);
      check("R9 result", addr_out, e1);
      check("R9 flag", carry_flag, c1);
      run_op("R9 r2 untouched", 2'b00, 2'd0, 2'd2, 2'd0, 1'b0, 16'h0, 1'b0);
   endtask

   task automatic t_b2b;
      load(2'd1, 16'h00F0);
      calc(2'b00, 2'd2, 2'd1, 2'd1, 1'b0, 16'h0, 1'b0);
      drive(2'b00, 2'd2, 2'd1, 2'd1, 1'b0, 16'h0, 1'b0);
      @(negedge clk); start = 1'b0;
      @(negedge clk); @(negedge clk); @(negedge clk);
      check("R10 first done", done, 1);
      calc(2'b01, 2'd3, 2'd2, 2'd0, 1'b1, 16'h0001, 1'b0);
      drive(2'b01, 2'd3, 2'd2, 2'd0, 1'b1, 16'h0001, 1'b0);
      @(negedge clk); start = 1'b0;
      check("R10 continues busy", busy, 1);
      check("R10 restarted", done, 0);
      @(negedge clk); @(negedge clk); @(negedge clk);
      check("R10 second done", done, 1);
      @(negedge clk);
      check("R10 chained result", addr_out, exp_res);
      check("R10 chained flag", carry_flag, exp_c);
   endtask

   task automatic t_idle;
      logic [15:0] a0;
      logic        f0;
      load(2'd1, 16'hFFFF);
      run_op("R12 setup", 2'b00, 2'd2, 2'd1, 2'd1, 1'b0, 16'h0, 1'b0);
      a0 = addr_out; f0 = carry_flag;
      op = 2'b10; a_sel = 2'd0; b_sel = 2'd3; imm_val = 16'h1111; use_imm = 1'b1;
      carry_in = 1'b0;
      repeat (5) @(negedge clk);
      check("R12 addr held", addr_out, a0);
      check("R12 flag held", carry_flag, f0);
      check("R12 no done", done, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_add();
      t_sub();
      t_logic();
      t_zero();
      t_inc();
      t_ignore();
      t_b2b();
      t_idle();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule